// File: doc/BRIEF.md
# Triggered-Update Phase-Accumulator Clock Synthesizer

This block produces a square clock by adding a tuning word to a 48-bit phase accumulator on every cycle of the system clock and driving the accumulator's top bit to the output. With a system clock of f_clk, the output frequency is f_clk * word / 2^48. For any f_clk up to several hundred megahertz, one step of the word is far below 0.075 Hz. An output range from 1 Hz to 105 MHz only needs f_clk above 210 MHz.

Software never changes the running frequency directly. The tuning word and an initial phase value are first written into staging registers, and writing either one arms a pending update. The update is applied either on the next cycle (immediate mode, the reset default) or on a rising edge of one of eight asynchronous trigger lines chosen by software. An update copies the staged word into the running register and loads the accumulator with the staged phase in the same cycle. When several units share the system clock and the trigger, they therefore restart in a known phase relation.

Top module: `dds_triggered_synth`

## Requirements
- R1: After reset `clk_out` is 0, `pending` is 0, the running word and the accumulator are 0, and immediate mode is selected. With no writes, `clk_out` stays 0.
- R2: On every clock cycle without an update, the accumulator advances by the running word modulo 2^48. `clk_out` equals accumulator bit 47.
- R3: A write with `wr_addr`=0 stages the tuning word, and a write with `wr_addr`=1 stages the initial phase. Each such write sets `pending` on the next cycle and leaves `clk_out` unchanged until an update. A write to address 3 has no effect.
- R4: In immediate mode, an armed update is applied at the first clock edge after the write. `pending` is high for exactly that one cycle.
- R5: A write with `wr_addr`=2 selects the update source. With `wr_data[3]`=1, trigger mode is selected on line `wr_data[2:0]`; with `wr_data[3]`=0, immediate mode is selected. This write does not arm an update.
- R6: In trigger mode, each trigger line passes through two synchronizing flops and a rising-edge detector. A line sampled high at clock edge a, after having been low, applies the armed update at edge a+2.
- R7: An update loads the staged word into the running register and the staged phase into the accumulator. On the cycle after the update, `clk_out` is bit 47 of the staged phase. The accumulator then advances by the new word.
- R8: The following have no effect on `clk_out` or `pending`: edges on trigger lines that are not selected, a selected line held high, and a selected-line edge while no update is armed.
- R9: If a staging write and an update fall in the same cycle, the update uses the previously staged values and `pending` stays set for the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock driving the accumulator |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 tuning word, 1 initial phase, 2 update source |
| wr_data | input | 48 | Write data |
| trig_in | input | 8 | Asynchronous trigger lines |
| clk_out | output | 1 | Synthesized square clock (accumulator MSB) |
| pending | output | 1 | A staged update is waiting to be applied |

## Verification
A wrong accumulator step or a wrong phase preload changes the cycle in which `clk_out` toggles. Large tuning words make the output toggle every few cycles, so such an error appears within a handful of cycles after the update. A wrong synchronizer depth or a wrong trigger-line selection moves the fall of `pending` and the start of the new frequency by whole cycles, which shows at the ports one to three cycles after the trigger. A staging error where a write leaks into the running register shows as `clk_out` diverging before any update has been applied.

// File: rtl/dds_pkg.sv
// Shared constants and types of the triggered phase-accumulator synthesizer.
package dds_pkg;
    localparam int ACC_W  = 48;
    localparam int TRIG_N = 8;
    localparam int SEL_W  = $clog2(TRIG_N);

    // Register addresses of the write port.
    typedef enum logic [1:0] {
        REG_WORD  = 2'd0,
        REG_PHASE = 2'd1,
        REG_SRC   = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/dds_trig_sync.sv
// Synchronizes each asynchronous trigger line with two flops and flags a
// rising edge for one cycle. Assumes lines are held for at least two cycles.
module dds_trig_sync #(
    parameter int N = dds_pkg::TRIG_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Two-flop synchronizer plus delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= trig_in[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        // One-cycle pulse on a synchronized low-to-high transition.
        assign rise[i] = sync_q[i] & ~prev_q[i];
    end
endmodule

// File: rtl/dds_stage_regs.sv
// Staging registers for tuning word and phase, update-source selection and
// the pending flag. Raises do_update when an armed update may be applied.
module dds_stage_regs #(
    parameter int ACC_W  = dds_pkg::ACC_W,
    parameter int TRIG_N = dds_pkg::TRIG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic [TRIG_N-1:0] rise,
    output logic [ACC_W-1:0]  word_shadow,
    output logic [ACC_W-1:0]  phase_shadow,
    output logic              pending,
    output logic              stage_wr,
    output logic              trig_mode,
    output logic              do_update
);
    import dds_pkg::*;
    localparam int SW = $clog2(TRIG_N);

    logic [SW-1:0] line_sel;
    logic          line_rise;

    // Writes to word or phase arm an update.
    assign stage_wr = wr_en && (wr_addr == REG_WORD || wr_addr == REG_PHASE);

    // Edge of the selected trigger line.
    assign line_rise = rise[line_sel];

    // Update fires when armed and the selected source permits it.
    assign do_update = pending && (!trig_mode || line_rise);

    // Register file and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_shadow  <= '0;
            phase_shadow <= '0;
            trig_mode    <= 1'b0;
            line_sel     <= '0;
            pending      <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    REG_WORD:  word_shadow  <= wr_data;
                    REG_PHASE: phase_shadow <= wr_data;
                    REG_SRC: begin
                        trig_mode <= wr_data[SW];
                        line_sel  <= wr_data[SW-1:0];
                    end
                    default: ;
                endcase
            end
            pending <= stage_wr || (pending && !do_update);
        end
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator with running tuning word. On an update the staged word
// becomes active and the accumulator is preloaded with the staged phase.
module dds_phase_acc #(
    parameter int ACC_W = dds_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_update,
    input  logic [ACC_W-1:0] word_shadow,
    input  logic [ACC_W-1:0] phase_shadow,
    output logic [ACC_W-1:0] word_active,
    output logic [ACC_W-1:0] acc,
    output logic             clk_out
);
    // Accumulate, or preload on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc         <= '0;
            word_active <= '0;
        end else if (do_update) begin
            acc         <= phase_shadow;
            word_active <= word_shadow;
        end else begin
            acc <= acc + word_active;
        end
    end

    // Square output is the accumulator MSB.
    assign clk_out = acc[ACC_W-1];
endmodule

// File: rtl/dds_triggered_synth.sv
// Top of the synthesizer: trigger synchronizers, staging registers and
// phase accumulator. Assumes one clock domain for the write port.
module dds_triggered_synth #(
    parameter int ACC_W  = dds_pkg::ACC_W,
    parameter int TRIG_N = dds_pkg::TRIG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic [TRIG_N-1:0] trig_in,
    output logic              clk_out,
    output logic              pending
);
    logic [TRIG_N-1:0] rise;
    logic [ACC_W-1:0]  word_shadow, phase_shadow, word_active, acc;
    logic              stage_wr, trig_mode, do_update;

    dds_trig_sync #(.N(TRIG_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise)
    );

    dds_stage_regs #(.ACC_W(ACC_W), .TRIG_N(TRIG_N)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rise(rise), .word_shadow(word_shadow),
        .phase_shadow(phase_shadow), .pending(pending), .stage_wr(stage_wr),
        .trig_mode(trig_mode), .do_update(do_update)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .do_update(do_update),
        .word_shadow(word_shadow), .phase_shadow(phase_shadow),
        .word_active(word_active), .acc(acc), .clk_out(clk_out)
    );
endmodule

// File: rtl/dds_triggered_synth_chk.sv
// Property checker bound to the synthesizer top.
module dds_triggered_synth_chk #(
    parameter int ACC_W = dds_pkg::ACC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             do_update,
    input logic             pending,
    input logic             stage_wr,
    input logic             trig_mode,
    input logic [ACC_W-1:0] word_shadow,
    input logic [ACC_W-1:0] phase_shadow,
    input logic [ACC_W-1:0] word_active,
    input logic [ACC_W-1:0] acc
);
    assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !do_update |=> acc == $past(acc) + $past(word_active));

    assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !do_update |=> $stable(word_active));

    assert_imm_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !trig_mode && !stage_wr) |=> !pending);

    assert_update_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_update |=> (acc == $past(phase_shadow)) && (word_active == $past(word_shadow)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !stage_wr) |=> !pending);

    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stage_wr |=> pending);
endmodule

bind dds_triggered_synth dds_triggered_synth_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .do_update(do_update), .pending(pending),
    .stage_wr(stage_wr), .trig_mode(trig_mode), .word_shadow(word_shadow),
    .phase_shadow(phase_shadow), .word_active(word_active), .acc(acc)
);

// File: tb/dds_triggered_synth_test.sv
module dds_triggered_synth_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [47:0] wr_data = '0;
    logic [7:0]  trig_in = '0;
    logic        clk_out, pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state, built from the requirements.
    logic [47:0] m_acc, m_act, m_word, m_ph;
    logic        m_pend, m_mode;
    logic [2:0]  m_line;
    logic [7:0]  s1, s2, s3;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_triggered_synth uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .clk_out(clk_out), .pending(pending)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_acc = '0; m_act = '0; m_word = '0; m_ph = '0;
        m_pend = 0; m_mode = 0; m_line = '0; s1 = '0; s2 = '0; s3 = '0;
    endfunction

    // One clock edge of the expected behaviour (R2..R9).
    function automatic void model_step(input logic we, input logic [1:0] a,
                                       input logic [47:0] d, input logic [7:0] tg);
        logic fire;
        fire = m_pend && (!m_mode || (s2[m_line] && !s3[m_line]));   // R4, R6
        if (fire) begin m_acc = m_ph; m_act = m_word; end             // R7
        else m_acc = m_acc + m_act;                                    // R2
        m_pend = (we && (a == 2'd0 || a == 2'd1)) || (m_pend && !fire); // R3, R9
        if (we) begin
            if (a == 2'd0) m_word = d;
            else if (a == 2'd1) m_ph = d;
            else if (a == 2'd2) begin m_mode = d[3]; m_line = d[2:0]; end // R5
        end
        s3 = s2; s2 = s1; s1 = tg;
    endfunction

    // Drive at the falling edge, model the rising edge, sample a quarter later.
    task automatic cyc(input logic we, input logic [1:0] a, input logic [47:0] d,
                       input logic [7:0] tg, input string req);
        wr_en = we; wr_addr = a; wr_data = d; trig_in = tg;
        @(posedge clk);
        model_step(we, a, d, tg);
        #(CLK_PERIOD/4);
        check(req, "clk_out", clk_out, m_acc[47]);
        check(req, "pending", pending, m_pend);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, '0, trig_in, req);
    endtask

    initial begin
        #(CLK_PERIOD*190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "clk_out after reset", clk_out, 1'b0);
        check("R1", "pending after reset", pending, 1'b0);
        idle(5, "R1");

        // R3/R4: immediate word write, output fast then phase preload (R7)
        cyc(1'b1, 2'd0, 48'h1000_0000_0000, 8'h00, "R4");
        idle(40, "R2");
        cyc(1'b1, 2'd1, 48'h8000_0000_0000, 8'h00, "R7");
        idle(6, "R7");
        cyc(1'b1, 2'd3, 48'hFFFF_FFFF_FFFF, 8'h00, "R3");
        idle(4, "R3");

        // R5/R6: trigger mode on line 5
        cyc(1'b1, 2'd2, 48'h0000_0000_000D, 8'h00, "R5");
        cyc(1'b1, 2'd0, 48'h3000_0000_0000, 8'h00, "R3");
        idle(10, "R3");
        // R8: edges on other lines are ignored
        cyc(1'b0, 2'd0, '0, 8'hDF, "R8");
        idle(8, "R8");
        cyc(1'b0, 2'd0, '0, 8'h00, "R8");
        idle(4, "R8");
        // R6: selected edge applies update two edges later
        cyc(1'b0, 2'd0, '0, 8'h20, "R6");
        idle(20, "R6");
        // R8: held high and edge with nothing armed
        cyc(1'b0, 2'd0, '0, 8'h00, "R8");
        idle(3, "R8");
        cyc(1'b0, 2'd0, '0, 8'h20, "R8");
        idle(10, "R8");

        // R9: write in the same cycle as the update
        cyc(1'b1, 2'd1, 48'h4000_0000_0000, 8'h00, "R9");
        idle(3, "R9");
        cyc(1'b0, 2'd0, '0, 8'h20, "R9");
        idle(1, "R9");
        cyc(1'b1, 2'd0, 48'h0800_0000_0001, 8'h20, "R9");
        idle(12, "R9");

        // Back to immediate mode with an update armed (R5, R4)
        cyc(1'b1, 2'd1, 48'h0, 8'h00, "R5");
        cyc(1'b1, 2'd2, 48'h0, 8'h00, "R5");
        idle(8, "R4");

        // Constrained random traffic
        for (int k = 0; k < 6000; k++) begin
            int r;
            logic [47:0] d;
            logic [7:0] tg;
            r = int'($urandom_range(0, 99));
            d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            if ((r % 3) == 0) d[47:40] = 8'h00;
            tg = trig_in;
            if ($urandom_range(0, 9) == 0) tg[$urandom_range(0, 7)] ^= 1'b1;
            if (r < 6)       cyc(1'b1, 2'd0, d, tg, "R3");
            else if (r < 11) cyc(1'b1, 2'd1, d, tg, "R7");
            else if (r < 13) cyc(1'b1, 2'd2, {44'd0, d[3:0]}, tg, "R5");
            else if (r < 14) cyc(1'b1, 2'd3, d, tg, "R3");
            else             cyc(1'b0, 2'd0, '0, tg, "R6");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule